// File: doc/BRIEF.md
# Quasi-Resonant Valley-Switching Off-Time Controller

This block decides when the main switch of a quasi-resonant flyback converter turns on again. Each switching period has three parts. The gate stays high until the current-mode comparator reports a turn-off event, or until a hard on-time cap is reached. The gate then stays low for a minimum off-time chosen from the feedback level. After that, a window opens in which a resonant valley pulse starts the next conduction after a short fixed delay.

Under heavy load the minimum off-time is short, so the converter follows the natural valleys. As the feedback level drops, the minimum off-time grows linearly. Below a green threshold with hysteresis, it jumps to a very long value, which folds the switching frequency down into the sub-kilohertz range. If no valley arrives, a time-out counted from the end of the minimum off-time forces the gate on.

A start timer sets the delay from enable to the first pulse. A soft-start counter ramps an allowed peak-level code from zero to full scale after enable. All timings are parameters in clock cycles, and the feedback level arrives as an unsigned code.

Top module: `qr_valley_ctrl`

## Requirements
- R1: While `en` is low, `gate` is low one cycle after `en` is sampled low, and every timer restarts from zero when `en` returns high.
- R2: The minimum off-time, latched at each turn-off, is chosen from the feedback code as follows.
  - If the code is at or above `GON_CODE`, the minimum off-time is `T_OFF_MIN`.
  - If the code lies between `GOFF_ENTER` and `GON_CODE`, it is `T_OFF_MIN + floor((GON_CODE - fb) * (T_OFF_GOFF - T_OFF_MIN) / (GON_CODE - GOFF_ENTER))`.
  - In green-off state it is `T_OFF_LONG`.
- R3: Green-off state is entered when the code is below `GOFF_ENTER` and left only when the code is at or above `GOFF_EXIT`. Between the two codes the previous state holds.
- R4: A `valley_det` pulse is accepted only when the count of low cycles since turn-off is at least the minimum off-time. Once a pulse is accepted, `gate` rises `T_DLY` cycles after the cycle in which it was sampled.
- R5: `valley_det` is ignored during the first `T_BLANK` low cycles after every turn-off, even if the minimum off-time is shorter.
- R6: If no valley is accepted, `gate` rises after exactly minimum off-time plus `T_TO` low cycles.
- R7: `gate` never stays high for more than `T_ON_MAX` consecutive cycles. Without a turn-off event it stays high for exactly that many.
- R8: When `cs_trip` is sampled high while `gate` is high, `gate` is low in the next cycle. `cs_trip` has no effect while the gate is low.
- R9: After `en` rises, the first pulse starts after a start delay chosen from the feedback code.
  - In green-off state the delay is `T_START_LONG`.
  - Otherwise, with the code at or above `OLP_CODE`, it is `T_START_SHORT`.
  - Otherwise it is the minimum off-time plus `T_TO`.
- R10: `ss_level` is `floor(k * (2^SSW - 1) / T_SS)` after `k` enabled cycles, saturating at full scale, and is zero one cycle after `en` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| fb_code | input | FBW | Quantised feedback level, higher means more load |
| valley_det | input | 1 | Resonant valley pulse from the auxiliary-winding detector |
| cs_trip | input | 1 | Turn-off event from the current-mode comparator |
| gate | output | 1 | Switch gate command |
| ss_level | output | SSW | Soft-start allowed peak-level code |

## Verification
The bench builds the block with off-times of 10, 40 and 200 cycles, a 12-cycle time-out, a 20-cycle on-time cap and a 64-cycle soft-start. With these values the green-mode long off-time, the full soft-start ramp and the longest start delay all fit in a short run. The blanking time is set above the shortest minimum off-time, so the blanking edge and the minimum off-time edge can each be probed one cycle on either side. The feedback vectors step into, through and back out of the hysteresis band, so the same code is seen to give two different off-times depending on direction.

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl #(
  parameter int FBW           = 8,
  parameter int SSW           = 8,
  parameter int GON_CODE      = 108,
  parameter int GOFF_ENTER    = 59,
  parameter int GOFF_EXIT     = 64,
  parameter int OLP_CODE      = 215,
  parameter int T_OFF_MIN     = 250,
  parameter int T_OFF_GOFF    = 1025,
  parameter int T_OFF_LONG    = 112500,
  parameter int T_TO          = 450,
  parameter int T_DLY         = 10,
  parameter int T_BLANK       = 125,
  parameter int T_ON_MAX      = 2250,
  parameter int T_START_SHORT = 1400,
  parameter int T_START_LONG  = 112500,
  parameter int T_SS          = 250000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [FBW-1:0] fb_code,
  input  logic           valley_det,
  input  logic           cs_trip,
  output logic           gate,
  output logic [SSW-1:0] ss_level
);

  localparam int SPAN_C = GON_CODE - GOFF_ENTER;
  localparam int SPAN_T = T_OFF_GOFF - T_OFF_MIN;
  localparam int M1 = (T_OFF_LONG + T_TO > T_OFF_GOFF + T_TO) ? T_OFF_LONG + T_TO : T_OFF_GOFF + T_TO;
  localparam int M2 = (M1 > T_START_LONG) ? M1 : T_START_LONG;
  localparam int M3 = (M2 > T_ON_MAX) ? M2 : T_ON_MAX;
  localparam int M4 = (M3 > T_START_SHORT) ? M3 : T_START_SHORT;
  localparam int M5 = (M4 > T_BLANK + T_DLY) ? M4 : T_BLANK + T_DLY;
  localparam int CW = $clog2(M5 + 2);
  localparam int SCW = $clog2(T_SS + 1);
  localparam int SS_MAX = (1 << SSW) - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ON, S_OFF, S_DLY} st_t;

  st_t           st;
  logic [CW-1:0] cnt, lim, tmin_q, tmin_c, start_c;
  logic          goff_q;
  logic [SCW-1:0] ss_cnt;
  int            fb_i, d_i;

  assign fb_i = int'(fb_code);
  assign gate = (st == S_ON);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   goff_q <= 1'b0;
    else if (fb_i < GOFF_ENTER)   goff_q <= 1'b1;
    else if (fb_i >= GOFF_EXIT)   goff_q <= 1'b0;

  always_comb begin
    d_i = GON_CODE - ((fb_i > GOFF_ENTER) ? fb_i : GOFF_ENTER);
    if (goff_q)                 tmin_c = CW'(T_OFF_LONG);
    else if (fb_i >= GON_CODE)  tmin_c = CW'(T_OFF_MIN);
    else                        tmin_c = CW'(T_OFF_MIN + (d_i * SPAN_T) / SPAN_C);
  end

  assign start_c = goff_q ? CW'(T_START_LONG) :
                   (fb_i >= OLP_CODE) ? CW'(T_START_SHORT) : tmin_c + CW'(T_TO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      lim    <= '0;
      tmin_q <= '0;
    end else if (!en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_START;
          cnt <= '0;
          lim <= start_c;
        end
        S_START:
          if (cnt == lim - CW'(1)) begin st <= S_ON; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        S_ON:
          if (cs_trip || cnt == CW'(T_ON_MAX - 1)) begin
            st     <= S_OFF;
            cnt    <= '0;
            tmin_q <= tmin_c;
          end else cnt <= cnt + CW'(1);
        S_OFF:
          if (valley_det && cnt >= tmin_q && cnt >= CW'(T_BLANK)) begin
            st <= S_DLY; cnt <= '0;
          end else if (cnt == tmin_q + CW'(T_TO - 1)) begin
            st <= S_ON; cnt <= '0;
          end else cnt <= cnt + CW'(1);
        S_DLY:
          if (cnt == CW'(T_DLY - 1)) begin st <= S_ON; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ss_cnt <= '0;
    else if (!en)                   ss_cnt <= '0;
    else if (ss_cnt != SCW'(T_SS))  ss_cnt <= ss_cnt + SCW'(1);

  assign ss_level = SSW'((64'(ss_cnt) * 64'(SS_MAX)) / 64'(T_SS));

  // run-length observers for the gate waveform
  logic [CW-1:0] hi_run, lo_run;
  logic          had_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      had_on <= 1'b0;
    end else begin
      hi_run <= gate ? hi_run + CW'(1) : '0;
      if (gate) lo_run <= '0;
      else if (lo_run != '1) lo_run <= lo_run + CW'(1);
      if (!en) had_on <= 1'b0;
      else if (gate) had_on <= 1'b1;
    end

  a_r1_disable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate);
  a_r7_on_cap: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> hi_run < CW'(T_ON_MAX));
  a_r8_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    gate && cs_trip |=> !gate);
  a_r4_min_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) && had_on |-> lo_run >= CW'(T_OFF_MIN));
  a_r6_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) && had_on |-> lo_run <= CW'(T_OFF_LONG + T_TO));
  a_r10_ss_mono: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) |-> ss_level >= $past(ss_level));
  a_r10_ss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ss_level == '0);

endmodule

// File: tb/qr_valley_ctrl_tb_top.sv
module qr_valley_ctrl_tb_top;
  localparam int FBW = 8, SSW = 6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, valley_det = 1'b0, cs_trip = 1'b0;
  logic [FBW-1:0] fb_code = 8'd200;
  logic gate;
  logic [SSW-1:0] ss_level;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  qr_valley_ctrl #(
    .FBW(FBW), .SSW(SSW), .GON_CODE(168), .GOFF_ENTER(92), .GOFF_EXIT(100),
    .OLP_CODE(230), .T_OFF_MIN(10), .T_OFF_GOFF(40), .T_OFF_LONG(200),
    .T_TO(12), .T_DLY(3), .T_BLANK(14), .T_ON_MAX(20), .T_START_SHORT(8),
    .T_START_LONG(150), .T_SS(64)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_code(fb_code), .valley_det(valley_det),
    .cs_trip(cs_trip), .gate(gate), .ss_level(ss_level)
  );

  localparam int NV = 10;
  localparam int VEC_FB [NV] = '{200, 168, 130, 100, 92, 91, 96, 99, 100, 96};
  localparam int VEC_OFF[NV] = '{ 22,  22,  37,  48, 52, 212, 212, 212, 48, 50};

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_run(input int fbv, output int n);
    en = 1'b0;
    fb_code = FBW'(fbv);
    repeat (4) @(negedge clk);
    en = 1'b1;
    n = 0;
    @(negedge clk);
    while (!gate) begin
      n++;
      if (n == 1)   check("R10 ramp k=1", int'(ss_level), 0);
      if (n == 32)  check("R10 ramp k=32", int'(ss_level), 31);
      if (n == 64)  check("R10 ramp k=64", int'(ss_level), 63);
      if (n == 100) check("R10 saturate", int'(ss_level), 63);
      @(negedge clk);
    end
  endtask

  task automatic run_off(input int k, output int n);
    while (!gate) @(negedge clk);
    while (gate) @(negedge clk);
    n = 1;
    forever begin
      if (n == k) valley_det = 1'b1;
      @(negedge clk);
      valley_det = 1'b0;
      if (gate) break;
      n++;
    end
  endtask

  task automatic run_on(input int k, output int n);
    while (gate) @(negedge clk);
    while (!gate) @(negedge clk);
    n = 1;
    forever begin
      if (n == k) cs_trip = 1'b1;
      @(negedge clk);
      cs_trip = 1'b0;
      if (!gate) break;
      n++;
    end
  endtask

  task automatic set_fb(input int v);
    fb_code = FBW'(v);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset gate", int'(gate), 0);
    check("R10 reset level", int'(ss_level), 0);

    start_run(50, r);  check("R9 start green-off", r, 150);
    start_run(240, r); check("R9 start open-loop", r, 8);
    start_run(200, r); check("R9 start normal", r, 22);

    run_on(0, r);  check("R7 on cap", r, 20);
    run_on(5, r);  check("R8 trip ends on", r, 5);
    run_on(0, r);  check("R8 trip ignored when low then full on", r, 20);

    // fb=200: min off 10, blanking 14 dominates
    run_off(15, r); check("R5 first valley after blank", r, 18);
    run_off(14, r); check("R5 valley inside blank ignored", r, 22);
    run_off(20, r); check("R4 delayed turn-on", r, 23);
    // fb=130: min off 25 dominates blanking
    set_fb(130);
    run_off(25, r); check("R4 valley before min off ignored", r, 37);
    run_off(26, r); check("R4 valley at min off", r, 29);

    for (int i = 0; i < NV; i++) begin
      set_fb(VEC_FB[i]);
      run_off(0, r);
      check((i < 5) ? "R2 off-time select R6 timeout" : "R3 hysteresis R6 timeout", r, VEC_OFF[i]);
    end

    while (!gate) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R1 disable mid-on", int'(gate), 0);
    check("R10 level cleared", int'(ss_level), 0);
    repeat (5) @(negedge clk);
    check("R1 stays low", int'(gate), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule